// File: doc/BRIEF.md
# Comparator Noise Filter and Edge Interrupt

This block conditions the outputs of two comparators before they reach an interrupt controller. Each comparator level is asynchronous to the system clock, so it is first brought into the clock domain. The synchronized level can then pass through an optional digital noise filter. The filter samples on a slow strobe chosen from the system clock, its clock divided by 8, or its clock divided by 32. It changes its output only when three samples in a row agree. The resulting level is watched for the chosen edge (rising, falling or either), and each matching edge produces a one-cycle interrupt pulse. A per-channel enable input gates that pulse.

One 8-bit configuration register, written through a single write strobe, holds the edge and filter settings of both channels. After a channel's filter setting changes, that channel holds back its interrupt for four sampling periods of the new setting. This hides transients while the filter state settles. Enabling the filter never creates an edge by itself, because the filter tracks the synchronized level whenever it is bypassed.

Top module: `cmp_cond_top`

## Requirements
- R1: While reset is held and after it is released, `irq` and `lvl` are 0, and the register reads as 0x00: both channels in bypass with rising-edge detection.
- R2: In bypass (filter field 00), a change on `cmp_raw[c]` appears on `lvl[c]` at the second clock edge after it is applied, through a two-flop synchronizer.
- R3: With the filter field at 01, `lvl[c]` takes a new value only at a sampling strobe where the last three samples of the synchronized level, including the current one, are all equal to that value.
- R4: Filter field 10 samples when bits [2:0] of a free-running 5-bit counter (reset to 0, +1 per clock) are all ones, and field 11 samples when all five bits are ones. Field 01 samples every clock.
- R5: Register layout, MSB first: [7] ch1 both-edges, [6] ch1 falling, [5:4] ch1 filter, [3] ch0 both-edges, [2] ch0 falling, [1:0] ch0 filter. Both-edges=0 with falling=0 selects the rising edge, both-edges=0 with falling=1 selects the falling edge, and both-edges=1 selects either edge whatever the falling bit is.
- R6: A selected edge of `lvl[c]` raises `irq[c]` for exactly one clock, one edge after `lvl[c]` changes.
- R7: While `irq_en[c]` is 0, a detected edge on channel c gives no pulse.
- R8: A write that changes a channel's filter field suppresses that channel's interrupts until four sampling strobes of the new setting have passed. With field 00, each clock counts as one strobe.
- R9: Switching a channel from bypass to a filtered mode does not change `lvl[c]` at the moment of the switch.
- R10: The two channels operate independently under their own fields, inputs and enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Configuration value to write |
| cmp_raw | input | 2 | Asynchronous comparator levels, one per channel |
| irq_en | input | 2 | Per-channel interrupt enable |
| lvl | output | 2 | Conditioned comparator level per channel |
| irq | output | 2 | One-cycle interrupt pulse per channel |

## Verification
The assertions assume that `cmp_raw` may toggle on any cycle and that `cfg_we` may arrive at any time. They assume nothing about the timing of reconfiguration, because the settle counter is meant to cover exactly that case. The stimulus drives every input half a period away from the active edge, so the synchronizer never sees a value change at the sampling instant. Within that limit, random hold times range from single-cycle glitches to stretches longer than a slow sampling period. Register writes land at random points of the prescaler cycle.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;
  typedef enum logic [1:0] {
    FSEL_OFF   = 2'b00,
    FSEL_FAST  = 2'b01,
    FSEL_MID   = 2'b10,
    FSEL_SLOW  = 2'b11
  } fsel_e;

  typedef struct packed {
    logic  both;
    logic  fall;
    fsel_e fsel;
  } chan_cfg_t;

  localparam int unsigned CH_CFG_W = $bits(chan_cfg_t);
  localparam int unsigned N_RATES  = 4;
endpackage

// File: rtl/cmpc_prescaler.sv
module cmpc_prescaler #(
  parameter int unsigned DIV_MID  = 8,
  parameter int unsigned DIV_SLOW = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [3:0] tick
);
  localparam int unsigned CNT_W = $clog2(DIV_SLOW);
  localparam int unsigned MID_W = $clog2(DIV_MID);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    tick[0] = 1'b1;
    tick[1] = 1'b1;
    tick[2] = &cnt_q[MID_W-1:0];
    tick[3] = &cnt_q;
  end

  AST_SLOW_IN_MID: assert property (@(posedge clk) disable iff (!rst_n)
    tick[3] |-> tick[2]); // R4
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R4
endmodule

// File: rtl/cmpc_channel.sv
module cmpc_channel
  import cmpc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned FILT_LEN     = 3,
  parameter int unsigned SETTLE_TICKS = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      raw,
  input  logic      en,
  input  chan_cfg_t cfg,
  input  logic      fsel_chg,
  input  logic [3:0] tick,
  output logic      lvl,
  output logic      irq
);
  localparam int unsigned SET_W = $clog2(SETTLE_TICKS + 1);

  // synchronizer
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   lvl_s;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], raw};
    lvl_s  = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  // noise filter
  logic [FILT_LEN-1:0] samp_q, samp_d, samp_sh;
  logic                filt_q, filt_d;
  logic                filt_on;
  logic                stb;

  always_comb begin
    filt_on = (cfg.fsel != FSEL_OFF);
    stb     = tick[cfg.fsel];
    samp_sh = {samp_q[FILT_LEN-2:0], lvl_s};
    samp_d  = samp_q;
    filt_d  = filt_q;
    if (!filt_on) begin
      samp_d = {FILT_LEN{lvl_s}};
      filt_d = lvl_s;
    end else if (stb) begin
      samp_d = samp_sh;
      if (&samp_sh)      filt_d = 1'b1;
      else if (~|samp_sh) filt_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      filt_q <= 1'b0;
    end else begin
      samp_q <= samp_d;
      filt_q <= filt_d;
    end
  end

  always_comb begin
    lvl = filt_on ? filt_q : lvl_s;
  end

  // settle window after filter reconfiguration
  logic [SET_W-1:0] settle_q, settle_d;

  always_comb begin
    settle_d = settle_q;
    if (fsel_chg)                  settle_d = SET_W'(SETTLE_TICKS);
    else if (settle_q != '0 && stb) settle_d = settle_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) settle_q <= '0;
    else        settle_q <= settle_d;
  end

  // edge detection and interrupt
  logic prev_q;
  logic hit;
  logic irq_q, irq_d;

  always_comb begin
    if (cfg.both)      hit = lvl ^ prev_q;
    else if (cfg.fall) hit = prev_q & ~lvl;
    else               hit = lvl & ~prev_q;
    irq_d = hit & en & (settle_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      irq_q  <= irq_d;
    end
  end

  assign irq = irq_q;

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_on && !stb) |=> $stable(filt_q)); // R3
  AST_IRQ_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($past(lvl) != $past(prev_q))); // R6
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(en)); // R7
  AST_SETTLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q != '0) |=> !irq_q); // R8
  AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    settle_q <= SET_W'(SETTLE_TICKS)); // R8
endmodule

// File: rtl/cmp_cond_top.sv
module cmp_cond_top
  import cmpc_pkg::*;
#(
  parameter int unsigned NCH          = 2,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned FILT_LEN     = 3,
  parameter int unsigned SETTLE_TICKS = 4,
  parameter int unsigned DIV_MID      = 8,
  parameter int unsigned DIV_SLOW     = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [NCH*CH_CFG_W-1:0] cfg_wdata,
  input  logic [NCH-1:0]          cmp_raw,
  input  logic [NCH-1:0]          irq_en,
  output logic [NCH-1:0]          lvl,
  output logic [NCH-1:0]          irq
);
  localparam int unsigned CFG_W = NCH * CH_CFG_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // configuration register
  logic [CFG_W-1:0] cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  logic [3:0] tick;

  cmpc_prescaler #(
    .DIV_MID  (DIV_MID),
    .DIV_SLOW (DIV_SLOW)
  ) u_pre (
    .clk   (clk),
    .rst_n (rst_i),
    .tick  (tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_cfg_t ccfg;
    chan_cfg_t wcfg;
    logic      chg;

    always_comb begin
      ccfg = chan_cfg_t'(cfg_q[c*CH_CFG_W +: CH_CFG_W]);
      wcfg = chan_cfg_t'(cfg_wdata[c*CH_CFG_W +: CH_CFG_W]);
      chg  = cfg_we && (wcfg.fsel != ccfg.fsel);
    end

    cmpc_channel #(
      .SYNC_STAGES  (SYNC_STAGES),
      .FILT_LEN     (FILT_LEN),
      .SETTLE_TICKS (SETTLE_TICKS)
    ) u_ch (
      .clk      (clk),
      .rst_n    (rst_i),
      .raw      (cmp_raw[c]),
      .en       (irq_en[c]),
      .cfg      (ccfg),
      .fsel_chg (chg),
      .tick     (tick),
      .lvl      (lvl[c]),
      .irq      (irq[c])
    );
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_i)
    !cfg_we |=> $stable(cfg_q)); // R5
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_i)
    cfg_we |=> cfg_q == $past(cfg_wdata)); // R5
endmodule

// File: tb/tb_cmp_cond_top.sv
`timescale 1ns/1ps
module tb_cmp_cond_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic [1:0] cmp_raw;
  logic [1:0] irq_en;
  logic [1:0] lvl;
  logic [1:0] irq;

  always #2 clk = ~clk;

  cmp_cond_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cmp_raw   (cmp_raw),
    .irq_en    (irq_en),
    .lvl       (lvl),
    .irq       (irq)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    chk_on = 1'b0;
  string cur_req = "R1";

  // reference model, built from the requirements
  logic [1:0] m_rs;
  logic [4:0] m_cnt;
  logic [7:0] m_cfg;
  logic [1:0] m_s1, m_s2, m_filt, m_prev, m_irq;
  logic [2:0] m_samp [2];
  logic [2:0] m_settle [2];

  function automatic logic [1:0] fld(input logic [7:0] cfg, input int c);
    return cfg[c*4 +: 2];
  endfunction

  function automatic logic m_lvl(input int c);
    return (fld(m_cfg, c) == 2'b00) ? m_s2[c] : m_filt[c];
  endfunction

  function automatic logic strobe(input logic [1:0] f, input logic [4:0] cnt);
    case (f)
      2'b10:   return cnt[2:0] == 3'b111;
      2'b11:   return cnt == 5'b11111;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic edge_hit(input logic both, input logic fall,
                                    input logic cur, input logic old);
    if (both)      return cur != old;
    else if (fall) return old & ~cur;
    else           return cur & ~old;
  endfunction

  task automatic m_clear();
    m_cnt = '0; m_cfg = '0; m_s1 = '0; m_s2 = '0; m_filt = '0;
    m_prev = '0; m_irq = '0;
    for (int c = 0; c < 2; c++) begin
      m_samp[c] = '0; m_settle[c] = '0;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 2'b00;
      m_clear();
    end else begin
      if (!m_rs[1]) begin
        m_clear();
      end else begin
        logic [7:0] ncfg;
        ncfg = cfg_we ? cfg_wdata : m_cfg;
        for (int c = 0; c < 2; c++) begin
          logic [1:0] f;
          logic       lv, st;
          logic [2:0] sh;
          f  = fld(m_cfg, c);
          lv = m_lvl(c);
          st = strobe(f, m_cnt);
          m_irq[c] = irq_en[c] && (m_settle[c] == 0) &&
                     edge_hit(m_cfg[c*4+3], m_cfg[c*4+2], lv, m_prev[c]);
          m_prev[c] = lv;
          if (f == 2'b00) begin
            m_samp[c] = {3{m_s2[c]}};
            m_filt[c] = m_s2[c];
          end else if (st) begin
            sh = {m_samp[c][1:0], m_s2[c]};
            m_samp[c] = sh;
            if (sh == 3'b111) m_filt[c] = 1'b1;
            if (sh == 3'b000) m_filt[c] = 1'b0;
          end
          if (cfg_we && fld(cfg_wdata, c) != f) m_settle[c] = 3'd4;
          else if (m_settle[c] != 0 && st)      m_settle[c] = m_settle[c] - 1;
        end
        m_s2  = m_s1;
        m_s1  = cmp_raw;
        m_cnt = m_cnt + 1;
        m_cfg = ncfg;
      end
      m_rs = {m_rs[0], 1'b1};
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      for (int c = 0; c < 2; c++) begin
        check(cur_req, $sformatf("irq[%0d]", c), 32'(irq[c]), 32'(m_irq[c]));
        check(cur_req, $sformatf("lvl[%0d]", c), 32'(lvl[c]), 32'(m_lvl(c)));
      end
    end
  end

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_rand(input int cycles, input int hold, input bit rnd_en,
                          input logic [1:0] chmask);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      for (int c = 0; c < 2; c++)
        if (chmask[c] && ($urandom % hold) == 0) cmp_raw[c] = ~cmp_raw[c];
      if (rnd_en) irq_en = 2'($urandom);
    end
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; cmp_raw = '0; irq_en = 2'b11;
    repeat (3) @(negedge clk);
    check("R1", "irq in reset", 32'(irq), 32'd0);
    check("R1", "lvl in reset", 32'(lvl), 32'd0);
    chk_on = 1'b1;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", "irq after reset", 32'(irq), 32'd0);

    // R2 and R6: bypass timing and single pulse
    cur_req = "R2";
    cmp_raw[0] = 1'b1;
    @(negedge clk); check("R2", "lvl0 after one edge", 32'(lvl[0]), 32'd0);
    @(negedge clk); check("R2", "lvl0 after two edges", 32'(lvl[0]), 32'd1);
    @(negedge clk); check("R6", "irq0 pulse", 32'(irq[0]), 32'd1);
    @(negedge clk); check("R6", "irq0 pulse ends", 32'(irq[0]), 32'd0);
    cmp_raw[0] = 1'b0;
    repeat (5) @(negedge clk);
    check("R1", "rising default ignores fall", 32'(irq[0]), 32'd0);

    // R5: edge modes in bypass
    cur_req = "R5";
    wr(8'b0100_0100); run_rand(300, 3, 1'b0, 2'b11);
    wr(8'b1000_1000); run_rand(300, 3, 1'b0, 2'b11);
    wr(8'b1100_1100); run_rand(300, 3, 1'b0, 2'b11);
    wr(8'b0000_1000); run_rand(300, 3, 1'b0, 2'b11);

    // R3: filter every clock, glitchy input
    cur_req = "R3";
    wr(8'b1001_1001); run_rand(800, 2, 1'b0, 2'b11);
    run_rand(800, 5, 1'b0, 2'b11);

    // R4: divided strobes
    cur_req = "R4";
    wr(8'b1010_1010); run_rand(2000, 6, 1'b0, 2'b11);
    wr(8'b1011_1011); run_rand(4000, 20, 1'b0, 2'b11);
    run_rand(2000, 50, 1'b0, 2'b11);

    // R7: random enables
    cur_req = "R7";
    wr(8'b1000_1000); run_rand(600, 3, 1'b1, 2'b11);
    irq_en = 2'b00; run_rand(300, 3, 1'b0, 2'b11);
    irq_en = 2'b11;

    // R9: enabling the filter with a steady high level
    cur_req = "R9";
    cmp_raw = 2'b11; repeat (6) @(negedge clk);
    wr(8'b1000_1001);
    check("R9", "lvl0 kept on enable", 32'(lvl[0]), 32'd1);
    repeat (3) @(negedge clk);
    check("R9", "lvl0 still high", 32'(lvl[0]), 32'd1);
    check("R9", "no irq0 on enable", 32'(irq[0]), 32'd0);

    // R8: reconfigure repeatedly while the inputs move
    cur_req = "R8";
    for (int k = 0; k < 40; k++) begin
      wr(8'($urandom));
      run_rand(20 + int'($urandom % 100), 2, 1'b0, 2'b11);
    end

    // R10: channels in different modes, one channel static
    cur_req = "R10";
    wr(8'b0100_1010); run_rand(1500, 4, 1'b1, 2'b01);
    run_rand(1500, 4, 1'b1, 2'b10);
    irq_en = 2'b11;
    run_rand(1000, 7, 1'b0, 2'b11);

    chk_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule